// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions a small set of external interrupt pins before they reach an interrupt controller. Each pin passes through a two-stage synchronizer. A per-pin detector then looks for a rising edge, a falling edge, either edge, a high level or a low level, and records each qualified event in a per-pin pending bit. A pending bit drives its request line only while the matching enable bit is set.

Software uses a 32-bit register bus with four word registers. The trigger-select word holds one 3-bit trigger code per pin, each in its own 4-bit slot. The pin-level word returns the synchronized pin levels and cannot be written. The pending word shows the recorded events; software clears a bit by writing 0 to it. The enable word gates the request lines. Reads are combinational from the address, and writes take effect on the rising clock edge.

Each pin's detector can be in one of six trigger states, decoded from its code: NONE (codes 0, 4, 7), RISE (1), FALL (2), BOTH (3), HIGH (5) and LOW (6). A code write moves the pin directly into the state that code names. In RISE, FALL and BOTH the pending bit is sticky. In HIGH and LOW it follows the qualified level. In NONE it holds its value until software clears it.

Top module: `exti_trigger_unit`

## Requirements
- R1: Directly after reset, every pin's trigger code is 6 (the trigger-select word reads 0x00666666 with six pins). The pending word, the enable word and all request lines read 0.
- R2: The trigger-select word sits at byte offset 0x0. Pin i's code occupies bits [4i+2:4i]. Bit 4i+3 and all bits above the last pin's slot read 0 whatever was written.
- R3: The pin-level word at offset 0x4 returns bit i as pin i after two clock edges of synchronization. A write to this offset changes nothing.
- R4: With code 1, a 0-to-1 transition of the synchronized pin sets the pending bit, and the bit stays set.
- R5: With code 2, a 1-to-0 transition sets the pending bit, and the bit stays set.
- R6: With code 3, either transition sets the pending bit, and the bit stays set.
- R7: With code 5, the pending bit equals the synchronized pin level, delayed by one clock.
- R8: With code 6, the pending bit equals the inverse of the synchronized pin level, delayed by one clock.
- R9: Codes 0, 4 and 7 never set a pending bit.
- R10: The pending word sits at offset 0x8. In an edge or no-trigger state, writing 0 to bit i clears it. Writing 1 never sets or changes a bit.
- R11: The enable word sits at offset 0xC and reads back what was written. Request line i equals pending bit i AND enable bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | External interrupt pins (asynchronous) |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr |
| irq_o | output | 6 | Request lines to the interrupt controller |

## Verification
The bench targets the codes that sit between the valid ones: a decoder that treated 4 or 7 as a level mode would report pending bits that should stay 0. It mixes pin patterns in which some pins rise and others fall, so that a swapped edge polarity or an edge detector comparing the wrong samples shows up as a wrong bit pattern. It checks that writing 1 to the pending word leaves the bits as they are, which exposes a design that uses set-on-write instead of clear-on-zero. It also checks that the reserved slot bits and a write to the pin-level word have no effect; a design with loose decoding would change stored state there.

// File: rtl/exti_pkg.sv
package exti_pkg;
    typedef enum logic [2:0] {
        TRIG_NONE = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_BOTH = 3'd3,
        TRIG_HIGH = 3'd4,
        TRIG_LOW  = 3'd5
    } trig_e;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned SLOT_W   = 4;
    localparam int unsigned DATA_W   = 32;
    localparam logic [1:0]  WORD_CFG = 2'd0;
    localparam logic [1:0]  WORD_LVL = 2'd1;
    localparam logic [1:0]  WORD_PND = 2'd2;
    localparam logic [1:0]  WORD_ENA = 2'd3;
    localparam logic [CODE_W-1:0] CODE_RESET = 3'd6;

    function automatic trig_e code_to_trig(input logic [CODE_W-1:0] code);
        unique case (code)
            3'd1:    return TRIG_RISE;
            3'd2:    return TRIG_FALL;
            3'd3:    return TRIG_BOTH;
            3'd5:    return TRIG_HIGH;
            3'd6:    return TRIG_LOW;
            default: return TRIG_NONE;
        endcase
    endfunction
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            sync_o  <= '0;
        end else begin
            stage_q <= async_i;
            sync_o  <= stage_q;
        end
    end
endmodule

// File: rtl/exti_chan.sv
module exti_chan
    import exti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clr_i,
    output logic              pend_o
);
    trig_e state;
    logic  prev_q;
    logic  pend_q;
    logic  pend_d;
    logic  rise;
    logic  fall;

    assign state = code_to_trig(code_i);
    assign rise  = lvl_i & ~prev_q;
    assign fall  = ~lvl_i & prev_q;

    always_comb begin
        pend_d = pend_q;
        unique case (state)
            TRIG_RISE: pend_d = rise ? 1'b1 : (clr_i ? 1'b0 : pend_q);
            TRIG_FALL: pend_d = fall ? 1'b1 : (clr_i ? 1'b0 : pend_q);
            TRIG_BOTH: pend_d = (rise | fall) ? 1'b1 : (clr_i ? 1'b0 : pend_q);
            TRIG_HIGH: pend_d = lvl_i;
            TRIG_LOW:  pend_d = ~lvl_i;
            TRIG_NONE: pend_d = clr_i ? 1'b0 : pend_q;
            default:   pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == TRIG_RISE || state == TRIG_FALL || state == TRIG_BOTH)
         && pend_q && !clr_i) |=> pend_q);
    // R7
    high_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRIG_HIGH) |=> (pend_q == $past(lvl_i)));
    // R8
    low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRIG_LOW) |=> (pend_q == !$past(lvl_i)));
    // R9
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRIG_NONE && !pend_q) |=> !pend_q);
endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int unsigned N_PINS = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [3:0]               bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic [N_PINS-1:0]        lvl_i,
    input  logic [N_PINS-1:0]        pend_i,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [N_PINS*CODE_W-1:0] codes_o,
    output logic [N_PINS-1:0]        clr_o,
    output logic [N_PINS-1:0]        en_o
);
    logic [1:0]        word;
    logic [N_PINS-1:0] en_q;
    logic              wr_cfg;
    logic              wr_ena;

    assign word   = bus_addr[3:2];
    assign wr_cfg = bus_wr && (word == WORD_CFG);
    assign wr_ena = bus_wr && (word == WORD_ENA);
    assign clr_o  = (bus_wr && (word == WORD_PND)) ? ~bus_wdata[N_PINS-1:0] : '0;

    for (genvar g = 0; g < N_PINS; g++) begin : g_slot
        logic [CODE_W-1:0] code_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      code_q <= CODE_RESET;
            else if (wr_cfg) code_q <= bus_wdata[g*SLOT_W +: CODE_W];
        end
        assign codes_o[g*CODE_W +: CODE_W] = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_ena) en_q <= bus_wdata[N_PINS-1:0];
    end
    assign en_o = en_q;

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            WORD_CFG: for (int i = 0; i < N_PINS; i++)
                          bus_rdata[i*SLOT_W +: CODE_W] = codes_o[i*CODE_W +: CODE_W];
            WORD_LVL: bus_rdata[N_PINS-1:0] = lvl_i;
            WORD_PND: bus_rdata[N_PINS-1:0] = pend_i;
            WORD_ENA: bus_rdata[N_PINS-1:0] = en_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R11
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ena |=> (en_q == $past(bus_wdata[N_PINS-1:0])));
endmodule

// File: rtl/exti_trigger_unit.sv
module exti_trigger_unit
    import exti_pkg::*;
#(
    parameter int unsigned N_PINS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_PINS-1:0] irq_o
);
    logic [N_PINS-1:0]        lvl;
    logic [N_PINS-1:0]        pend;
    logic [N_PINS-1:0]        clr;
    logic [N_PINS-1:0]        en;
    logic [N_PINS*CODE_W-1:0] codes;

    exti_sync #(.WIDTH(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(lvl)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_chan
        exti_chan u_chan (
            .clk(clk), .rst_n(rst_n), .lvl_i(lvl[g]),
            .code_i(codes[g*CODE_W +: CODE_W]), .clr_i(clr[g]), .pend_o(pend[g])
        );
    end

    exti_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .lvl_i(lvl), .pend_i(pend), .bus_rdata(bus_rdata),
        .codes_o(codes), .clr_o(clr), .en_o(en)
    );

    assign irq_o = pend & en;

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == WORD_ENA && bus_wdata[N_PINS-1:0] == '0)
        |=> (irq_o == '0));
endmodule

// File: tb/sim_exti_trigger_unit.sv
module sim_exti_trigger_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pin_i = 6'h3F;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exti_trigger_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // {code[2:0], pins_before[5:0], pins_after[5:0], expected_pending[5:0]}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {3'd1, 6'h00, 6'h3F, 6'h3F},   // R4
        {3'd1, 6'h2A, 6'h0F, 6'h05},   // R4
        {3'd2, 6'h3F, 6'h00, 6'h3F},   // R5
        {3'd2, 6'h2A, 6'h0F, 6'h20},   // R5
        {3'd3, 6'h2A, 6'h0F, 6'h25},   // R6
        {3'd3, 6'h00, 6'h00, 6'h00},   // R6
        {3'd5, 6'h00, 6'h2A, 6'h2A},   // R7
        {3'd5, 6'h3F, 6'h11, 6'h11},   // R7
        {3'd6, 6'h00, 6'h2A, 6'h15},   // R8
        {3'd6, 6'h3F, 6'h3F, 6'h00},   // R8
        {3'd0, 6'h00, 6'h3F, 6'h00},   // R9
        {3'd4, 6'h3F, 6'h00, 6'h00},   // R9
        {3'd7, 6'h15, 6'h2A, 6'h00}    // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h, expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: sampled before the first edge after reset release
        bus_addr = 4'h0; #1 check("R1 cfg", bus_rdata, 32'h0066_6666);
        bus_addr = 4'h8; #1 check("R1 pend", bus_rdata, 32'h0);
        bus_addr = 4'hC; #1 check("R1 enable", bus_rdata, 32'h0);
        check("R1 irq", {26'h0, irq_o}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] c;
            logic [31:0] word;
            c = VEC[v][20:18];
            word = '0;
            for (int p = 0; p < 6; p++) word[p*4 +: 3] = c;
            wr(4'h0, word);
            pin_i = VEC[v][17:12];
            settle();
            wr(4'h8, 32'h0);
            pin_i = VEC[v][11:6];
            settle();
            rd(4'h8, r);
            check($sformatf("R4-9 vector %0d code %0d", v, c), r, {26'h0, VEC[v][5:0]});
        end

        // R2: reserved bits stay zero
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, r); check("R2 cfg mask", r, 32'h0077_7777);

        // R3: level word and write immunity
        wr(4'h0, 32'h0);
        pin_i = 6'h2B; settle();
        rd(4'h4, r); check("R3 level", r, 32'h2B);
        wr(4'h4, 32'h0000_0014);
        rd(4'h4, r); check("R3 write ignored", r, 32'h2B);

        // R10: clear-on-zero, one writes ignored (rising mode)
        wr(4'h0, 32'h0011_1111);
        pin_i = 6'h00; settle();
        wr(4'h8, 32'h0);
        wr(4'h8, 32'h3F);
        rd(4'h8, r); check("R10 write one no set", r, 32'h0);
        pin_i = 6'h3F; settle();
        wr(4'h8, 32'h3F);
        rd(4'h8, r); check("R10 write one keeps", r, 32'h3F);
        wr(4'h8, 32'h3E);
        rd(4'h8, r); check("R10 zero clears bit0", r, 32'h3E);

        // R11: enable gating
        wr(4'hC, 32'h05);
        rd(4'hC, r); check("R11 enable readback", r, 32'h05);
        check("R11 irq gating", {26'h0, irq_o}, 32'h04);
        wr(4'hC, 32'h0);
        #1 check("R11 irq off", {26'h0, irq_o}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule